// File: doc/BRIEF.md
# Masked XOR Response Compactor

This block sits at the unload side of a compressed scan architecture. Many internal scan chains shift their captured responses out in parallel, and the block folds them into a handful of scan-out bits by spatial XOR reduction. Each output bit is the parity of one fixed group of chains. This cuts the number of pins and the amount of response data that the tester has to compare.

Some chains carry unknown values after capture, and an unknown fed into an XOR corrupts the whole group it belongs to. A per-chain mask register is therefore placed in front of the reduction. A set mask bit forces that chain to logic 0 before it joins its group. The parity of the other chains in the group is then left unchanged, and the unknown value is removed. A new mask is shifted in serially before each pattern's unload and stays in place until the next load. The compacted bits are the only response observed in each shift cycle. They can leave the block combinationally or through one register stage, selected by a parameter.

Top module: `xor_resp_compactor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the mask register holds all zeros, so no chain is masked. With `OUT_REG`=1, `scan_out` reads 0 in the cycle after a reset edge.
- R2: On each rising clock edge with `mask_load_en` high, `mask_sdi` enters mask bit `N_CHAIN-1` and every other bit moves one place toward bit 0. After `N_CHAIN` such edges, the bit shifted in first controls chain 0 and the bit shifted in last controls chain `N_CHAIN-1`.
- R3: While `mask_load_en` is low, the mask holds its value whatever `mask_sdi` does.
- R4: A chain whose mask bit is 1 is forced to 0 before the reduction. Toggling that chain never changes `scan_out`.
- R5: Chain i feeds only output bit i mod `N_OUT`. With the defaults (120 chains, 4 outputs), each output bit collects 30 chains.
- R6: Output bit g equals the XOR of all unmasked chains i with i mod `N_OUT` = g.
- R7: An unknown value on a masked chain never appears on any `scan_out` bit.
- R8: With `OUT_REG`=1, `scan_out` shows the result of the chain and mask values present at the previous rising edge. With `OUT_REG`=0, `scan_out` follows its inputs in the same cycle.
- R9: When every chain of a group is masked, that group's output bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_in | input | N_CHAIN | One response bit from each scan chain |
| mask_load_en | input | 1 | Shift enable for the serial mask load |
| mask_sdi | input | 1 | Serial mask data, first bit ends at chain 0 |
| scan_out | output | N_OUT | Compacted, masked response bits |

## Verification
The bench builds two copies of the block at the default width of 120 chains into 4 outputs. One copy uses `OUT_REG`=1 and the other `OUT_REG`=0, so a single stimulus stream checks the one-cycle latency against the combinational path. The full width places 30 chains in every group, with chain 0 and chain 119 at the two ends of the serial mask. Random masks and random chain data are mixed with directed cases: single hot chains, whole masked groups, unknowns driven onto masked chains, and toggling of masked chains.

// File: rtl/comp_pkg.sv
package comp_pkg;

  // Number of chains i in [0, n_chain) with i % n_out == g.
  function automatic int group_size(input int n_chain, input int n_out, input int g);
    return (n_chain - g + n_out - 1) / n_out;
  endfunction

endpackage

// File: rtl/mask_shreg.sv
module mask_shreg #(
  parameter int N_CHAIN = 120
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic               sdi,
  output logic [N_CHAIN-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
    end else if (load_en) begin
      mask_q <= {sdi, mask_q[N_CHAIN-1:1]};
    end
  end

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '0)); // R1

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_en)) |-> $stable(mask_q)); // R3

  AST_MASK_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_en)) |-> (mask_q[N_CHAIN-1] == $past(sdi))); // R2

endmodule

// File: rtl/chain_gate.sv
module chain_gate #(
  parameter int N_CHAIN = 120
) (
  input  logic [N_CHAIN-1:0] chain_in,
  input  logic [N_CHAIN-1:0] mask,
  output logic [N_CHAIN-1:0] gated
);

  // A masked chain is forced to 0 so it is neutral in the XOR.
  for (genvar i = 0; i < N_CHAIN; i++) begin : g_gate
    assign gated[i] = mask[i] ? 1'b0 : chain_in[i];
  end

endmodule

// File: rtl/xor_group.sv
module xor_group #(
  parameter int N_CHAIN = 120,
  parameter int N_OUT   = 4,
  parameter int G       = 0
) (
  input  logic [N_CHAIN-1:0] gated,
  output logic               parity
);

  localparam int GS = comp_pkg::group_size(N_CHAIN, N_OUT, G);

  logic [GS-1:0] members;

  for (genvar k = 0; k < GS; k++) begin : g_pick
    assign members[k] = gated[G + k * N_OUT];
  end

  assign parity = ^members;

endmodule

// File: rtl/out_reg.sv
module out_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  AST_OUT_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == '0)); // R1

endmodule

// File: rtl/xor_resp_compactor.sv
module xor_resp_compactor #(
  parameter int N_CHAIN = 120,
  parameter int N_OUT   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_CHAIN-1:0] chain_in,
  input  logic               mask_load_en,
  input  logic               mask_sdi,
  output logic [N_OUT-1:0]   scan_out
);

  logic [N_CHAIN-1:0] mask_q;
  logic [N_CHAIN-1:0] gated;
  logic [N_OUT-1:0]   grp_par;
  logic [N_OUT-1:0]   grp_all_masked;

  mask_shreg #(.N_CHAIN(N_CHAIN)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .load_en (mask_load_en),
    .sdi     (mask_sdi),
    .mask_q  (mask_q)
  );

  chain_gate #(.N_CHAIN(N_CHAIN)) u_gate (
    .chain_in (chain_in),
    .mask     (mask_q),
    .gated    (gated)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_grp
    xor_group #(.N_CHAIN(N_CHAIN), .N_OUT(N_OUT), .G(g)) u_xor (
      .gated  (gated),
      .parity (grp_par[g])
    );
  end

  if (OUT_REG) begin : g_reg
    out_reg #(.W(N_OUT)) u_oreg (
      .clk (clk),
      .rst (rst),
      .d   (grp_par),
      .q   (scan_out)
    );
  end else begin : g_comb
    assign scan_out = grp_par;
  end

  // Guard: a fully masked group must yield a zero parity bit.
  always_comb begin
    grp_all_masked = '1;
    for (int i = 0; i < N_CHAIN; i++) begin
      if (!mask_q[i]) grp_all_masked[i % N_OUT] = 1'b0;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_chk
    AST_MASKED_GROUP_ZERO: assert property (@(posedge clk) disable iff (rst)
      grp_all_masked[g] |-> (grp_par[g] == 1'b0)); // R9
  end

endmodule

// File: tb/xor_resp_compactor_bench.sv
module xor_resp_compactor_bench;

  localparam int NC = 120;
  localparam int NO = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] chain_in = '0;
  logic          mask_load_en = 1'b0;
  logic          mask_sdi = 1'b0;
  logic [NO-1:0] out_r;
  logic [NO-1:0] out_c;

  logic [NC-1:0] mdl_mask = '0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xor_resp_compactor #(.N_CHAIN(NC), .N_OUT(NO), .OUT_REG(1'b1)) u_xor_resp_compactor (
    .clk (clk), .rst (rst), .chain_in (chain_in),
    .mask_load_en (mask_load_en), .mask_sdi (mask_sdi), .scan_out (out_r)
  );

  xor_resp_compactor #(.N_CHAIN(NC), .N_OUT(NO), .OUT_REG(1'b0)) u_xor_resp_compactor_comb (
    .clk (clk), .rst (rst), .chain_in (chain_in),
    .mask_load_en (mask_load_en), .mask_sdi (mask_sdi), .scan_out (out_c)
  );

  function automatic logic [NO-1:0] expect_out(input logic [NC-1:0] v, input logic [NC-1:0] m);
    logic [NO-1:0] e = '0;
    for (int i = 0; i < NC; i++) begin
      if (!m[i]) e[i % NO] = e[i % NO] ^ v[i];
    end
    return e;
  endfunction

  function automatic logic [NC-1:0] rand_vec(input int density);
    logic [NC-1:0] v;
    logic [31:0] r;
    for (int i = 0; i < NC; i++) begin
      r = $urandom;
      v[i] = ((r % 100) < density);
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load_mask(input logic [NC-1:0] m);
    for (int k = 0; k < NC; k++) begin
      @(negedge clk);
      mask_load_en = 1'b1;
      mask_sdi = m[k];
    end
    @(negedge clk);
    mask_load_en = 1'b0;
    mdl_mask = m;
  endtask

  // Drive a vector, check the combinational copy at once, then both copies a cycle on.
  task automatic apply(input logic [NC-1:0] v, input string req);
    logic [NO-1:0] e;
    logic [NO-1:0] prev;
    logic [31:0] r;
    @(negedge clk);
    prev = out_r;
    chain_in = v;
    r = $urandom;
    mask_sdi = r[0]; // R3: serial data wiggles while load is off
    e = expect_out(v, mdl_mask);
    #1;
    check(out_c === e, {req, " comb R8"}, out_c, e);
    check(out_r === prev, {req, " reg holds until edge R8"}, out_r, prev);
    @(negedge clk);
    check(out_c === e, {req, " comb"}, out_c, e);
    check(out_r === e, {req, " reg"}, out_r, e);
    check(!$isunknown(out_r) && !$isunknown(out_c), {req, " known R7"}, out_r, e);
  endtask

  initial begin
    logic [NC-1:0] v;
    logic [NC-1:0] m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_r === '0, "R1 reg out in reset", out_r, '0);
    @(negedge clk);
    rst = 1'b0;
    // R1: mask cleared, every chain contributes
    for (int t = 0; t < 4; t++) apply(rand_vec(50), "R1 no mask after reset");

    // R5: single hot chains land on i mod NO
    foreach (v[i]) v[i] = 1'b0;
    for (int k = 0; k < 6; k++) begin
      int idx;
      idx = (k == 0) ? 0 : (k == 5) ? NC - 1 : (k * 23) % NC;
      v = '0;
      v[idx] = 1'b1;
      apply(v, "R5 single hot chain");
    end

    // R2: order of serial load; only chain 0 and chain NC-1 left unmasked
    m = '1; m[0] = 1'b0; m[NC-1] = 1'b0;
    load_mask(m);
    apply('1, "R2 first bit at chain 0");
    v = '0; v[0] = 1'b1;
    apply(v, "R2 chain 0 alone");

    // R9: group 2 fully masked
    m = '0;
    for (int i = 2; i < NC; i += NO) m[i] = 1'b1;
    load_mask(m);
    for (int t = 0; t < 4; t++) begin
      apply(rand_vec(50), "R9 masked group");
      check(out_r[2] === 1'b0, "R9 group 2 zero", out_r, '0);
    end

    // R4 / R7: toggle and X on masked chains
    m = rand_vec(40);
    load_mask(m);
    v = rand_vec(50);
    apply(v, "R4 base");
    for (int i = 0; i < NC; i++) if (m[i]) v[i] = ~v[i];
    apply(v, "R4 masked chains toggled");
    for (int i = 0; i < NC; i++) if (m[i]) v[i] = 1'bx;
    apply(v, "R7 unknown on masked chains");

    // R3: mask stays put across idle cycles
    repeat (5) begin
      @(negedge clk);
      mask_sdi = ~mask_sdi;
    end
    apply(rand_vec(50), "R3 mask hold");

    // R6: random masks and data
    for (int p = 0; p < 30; p++) begin
      load_mask(rand_vec((p * 7) % 100));
      for (int t = 0; t < 8; t++) apply(rand_vec(50), "R6 random parity");
    end

    // R1: reset in mid-run clears the mask
    load_mask('1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_r === '0, "R1 reg out after reset edge", out_r, '0);
    rst = 1'b0;
    mdl_mask = '0;
    apply(rand_vec(50), "R1 mask cleared by reset");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule